// File: doc/BRIEF.md
# One-Time-Programmable Trim Fuse Sequencer

This block makes a 6-bit trim setting permanent. Before that happens, the setting lives in a volatile wiper register that software can rewrite as often as it likes. A power-on reset loads that register with midscale. When a program request arrives, the sequencer runs a fixed sequence:

1. It blows a setup test fuse and reads it back.
2. It burns the data fuses one bit per clock.
3. It compares the fused code with the wiper register.
4. It blows a lock fuse.

The result is recorded in a sticky 2-bit outcome code. Once the part is locked, the effective trim code always comes from the fuses, including after every later power-on.

The fuses are behavioural sticky bits that no reset clears. Each fuse has a fault-injection input that stops it from reaching the blown state, so a test environment can produce every outcome. Only one programming attempt is ever accepted in the life of a part.

Top module: `otp_trim_sequencer`

## Requirements
- R1: After power-on reset a fresh part shows outcome 00 (ready), busy low, locked low, and effective code 0x20 (midscale of the 6-bit code).
- R2: While idle and unlocked, a write with wr_en high loads wr_code, and eff_code shows it one cycle later. Writes made while busy is high are ignored.
- R3: If the test fuse does not read back as blown, the outcome becomes 01. Busy is high for exactly 2 sampled cycles. No data fuse or lock fuse is blown, so locked stays low.
- R4: Data fuses are blown one per clock over CODE_W consecutive cycles. Fuse i is blown only when wiper bit i is 1, and a blown fuse reads as 1. A complete successful run keeps busy high for 11 cycles.
- R5: If the fused code differs from the wiper register, the outcome becomes 10 (fatal), the lock fuse is not blown, and busy is high for 9 cycles.
- R6: When the codes match, the lock fuse is blown, the outcome becomes 11 and locked goes high.
- R7: While locked, eff_code equals the fused code and wiper writes have no effect on it.
- R8: A program request made while the outcome is not 00 is ignored: busy stays low and the outcome is unchanged.
- R9: The outcome code and the fuses survive power-on reset. The wiper register of an unlocked part returns to 0x20, and a locked part keeps showing its fused code.
- R10: If the lock fuse fails to blow after a good compare, the outcome becomes 10 and locked stays low.
- R11: A data-fuse fault on a bit whose wiper value is 0 has no effect, and programming ends with outcome 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| prog_req | input | 1 | Request to burn the current wiper code |
| wr_en | input | 1 | Wiper register write strobe |
| wr_code | input | CODE_W | Wiper code to write |
| flt_test | input | 1 | Fault injection: test fuse cannot blow |
| flt_data | input | CODE_W | Fault injection: per data fuse, cannot blow |
| flt_lock | input | 1 | Fault injection: lock fuse cannot blow |
| status | output | 2 | Outcome: 00 ready, 01 test fuse failed, 10 fatal, 11 locked |
| busy | output | 1 | Sequence in progress |
| eff_code | output | CODE_W | Effective trim code (fuses when locked, else wiper register) |
| locked | output | 1 | Lock fuse is blown |

## Verification
The bench builds five parts with the default CODE_W of 6. They differ only in their fault-injection settings: clean, test-fuse fault, a data-fuse fault on a one bit, a lock-fuse fault, and a data-fuse fault on a zero bit. The fuses can never be cleared, so this is the only way to reach every outcome of the single allowed attempt in one run. After programming, a shared power-on reset shows which state each part retains. Repeat requests then show that no part, whatever its outcome, accepts a second attempt.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_TEST,
        S_TCHK,
        S_DATA,
        S_CMP,
        S_LOCK,
        S_LCHK
    } seq_state_e;

    localparam logic [1:0] ST_READY    = 2'b00;
    localparam logic [1:0] ST_TESTFAIL = 2'b01;
    localparam logic [1:0] ST_FATAL    = 2'b10;
    localparam logic [1:0] ST_GOOD     = 2'b11;
endpackage

// File: rtl/otp_fuse_bank.sv
// Behavioural non-volatile record: fuses plus outcome code. No reset clears it.
module otp_fuse_bank #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              blow_test,
    input  logic [CODE_W-1:0] blow_data,
    input  logic              blow_lock,
    input  logic              flt_test,
    input  logic [CODE_W-1:0] flt_data,
    input  logic              flt_lock,
    input  logic              st_wr,
    input  logic [1:0]        st_val,
    output logic              test_blown,
    output logic [CODE_W-1:0] data_fuse,
    output logic              lock_blown,
    output logic [1:0]        status
);
    typedef struct packed {
        logic              test;
        logic [CODE_W-1:0] data;
        logic              lock;
        logic [1:0]        st;
    } nv_t;

    nv_t nv_q = '0;
    nv_t nv_d;

    always_comb begin
        nv_d      = nv_q;
        nv_d.test = nv_q.test | (blow_test & ~flt_test);
        nv_d.data = nv_q.data | (blow_data & ~flt_data);
        nv_d.lock = nv_q.lock | (blow_lock & ~flt_lock);
        if (st_wr) begin
            nv_d.st = st_val;
        end
    end

    always_ff @(posedge clk) begin
        nv_q <= nv_d;
    end

    assign test_blown = nv_q.test;
    assign data_fuse  = nv_q.data;
    assign lock_blown = nv_q.lock;
    assign status     = nv_q.st;
endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
    import otp_seq_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic [CODE_W-1:0] wiper,
    input  logic [1:0]        status,
    input  logic              test_blown,
    input  logic [CODE_W-1:0] data_fuse,
    input  logic              lock_blown,
    output logic              blow_test,
    output logic [CODE_W-1:0] blow_data,
    output logic              blow_lock,
    output logic              st_wr,
    output logic [1:0]        st_val,
    output logic              busy
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d     = ctl_q;
        blow_test = 1'b0;
        blow_data = '0;
        blow_lock = 1'b0;
        st_wr     = 1'b0;
        st_val    = ST_READY;
        case (ctl_q.state)
            S_IDLE: begin
                if (prog_req && status == ST_READY) begin
                    ctl_d.state = S_TEST;
                end
            end
            S_TEST: begin
                blow_test   = 1'b1;
                ctl_d.state = S_TCHK;
            end
            S_TCHK: begin
                if (!test_blown) begin
                    st_wr       = 1'b1;
                    st_val      = ST_TESTFAIL;
                    ctl_d.state = S_IDLE;
                end else begin
                    ctl_d.idx   = '0;
                    ctl_d.state = S_DATA;
                end
            end
            S_DATA: begin
                blow_data[ctl_q.idx] = wiper[ctl_q.idx];
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.state = S_CMP;
                end else begin
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end
            S_CMP: begin
                if (data_fuse != wiper) begin
                    st_wr       = 1'b1;
                    st_val      = ST_FATAL;
                    ctl_d.state = S_IDLE;
                end else begin
                    ctl_d.state = S_LOCK;
                end
            end
            S_LOCK: begin
                blow_lock   = 1'b1;
                ctl_d.state = S_LCHK;
            end
            S_LCHK: begin
                st_wr       = 1'b1;
                st_val      = lock_blown ? ST_GOOD : ST_FATAL;
                ctl_d.state = S_IDLE;
            end
            default: ctl_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: S_IDLE, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.state != S_IDLE);

    // R8: a request against a used part never starts a sequence
    a_r8_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prog_req && status != ST_READY) |=> !busy);

    // R4: at most one data fuse is driven in any cycle
    a_r4_one_data_fuse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blow_data));

    // R3: a failed test fuse leaves the data and lock fuses untouched
    a_r3_testfail_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_val == ST_TESTFAIL) |-> (data_fuse == '0 && !lock_blown));

    // R5: a compare mismatch ends the run without touching the lock fuse
    a_r5_no_lock_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_CMP && data_fuse != wiper) |=> (!blow_lock && !busy && !lock_blown));
endmodule

// File: rtl/otp_trim_sequencer.sv
module otp_trim_sequencer
    import otp_seq_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              flt_test,
    input  logic [CODE_W-1:0] flt_data,
    input  logic              flt_lock,
    output logic [1:0]        status,
    output logic              busy,
    output logic [CODE_W-1:0] eff_code,
    output logic              locked
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] wiper;
    } top_t;

    top_t top_q, top_d;

    logic              blow_test, blow_lock, st_wr, test_blown, lock_blown;
    logic [CODE_W-1:0] blow_data, data_fuse;
    logic [1:0]        st_val;

    always_comb begin
        top_d = top_q;
        if (wr_en && !busy && !lock_blown) begin
            top_d.wiper = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{wiper: MID_CODE};
        end else begin
            top_q <= top_d;
        end
    end

    otp_seq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_req   (prog_req),
        .wiper      (top_q.wiper),
        .status     (status),
        .test_blown (test_blown),
        .data_fuse  (data_fuse),
        .lock_blown (lock_blown),
        .blow_test  (blow_test),
        .blow_data  (blow_data),
        .blow_lock  (blow_lock),
        .st_wr      (st_wr),
        .st_val     (st_val),
        .busy       (busy)
    );

    otp_fuse_bank #(.CODE_W(CODE_W)) u_bank (
        .clk        (clk),
        .blow_test  (blow_test),
        .blow_data  (blow_data),
        .blow_lock  (blow_lock),
        .flt_test   (flt_test),
        .flt_data   (flt_data),
        .flt_lock   (flt_lock),
        .st_wr      (st_wr),
        .st_val     (st_val),
        .test_blown (test_blown),
        .data_fuse  (data_fuse),
        .lock_blown (lock_blown),
        .status     (status)
    );

    assign locked   = lock_blown;
    assign eff_code = lock_blown ? data_fuse : top_q.wiper;

    // R2: the wiper register holds while a sequence runs
    a_r2_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(top_q.wiper));

    // R7: the wiper register holds once locked
    a_r7_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(top_q.wiper));

    // R6: the success outcome always comes with a blown lock fuse
    a_r6_good_has_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_GOOD) |-> locked);
endmodule

// File: tb/otp_trim_sequencer_tb.sv
module otp_trim_sequencer_tb;
    localparam int W  = 6;
    localparam int NP = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_req [NP];
    logic         wr_en    [NP];
    logic [W-1:0] wr_code  [NP];
    logic         flt_test [NP];
    logic [W-1:0] flt_data [NP];
    logic         flt_lock [NP];
    logic [1:0]   status   [NP];
    logic         busy     [NP];
    logic [W-1:0] eff_code [NP];
    logic         locked   [NP];

    always #10 clk = ~clk;

    for (genvar g = 0; g < NP; g++) begin : g_part
        otp_trim_sequencer #(.CODE_W(W)) u_dut (
            .clk      (clk),
            .rst_n    (rst_n),
            .prog_req (prog_req[g]),
            .wr_en    (wr_en[g]),
            .wr_code  (wr_code[g]),
            .flt_test (flt_test[g]),
            .flt_data (flt_data[g]),
            .flt_lock (flt_lock[g]),
            .status   (status[g]),
            .busy     (busy[g]),
            .eff_code (eff_code[g]),
            .locked   (locked[g])
        );
    end

    typedef struct {
        int         part;
        logic [1:0] st;
        int         cyc;
        logic [W-1:0] eff;
        logic       lk;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected outcomes and compares once busy drops
    initial begin
        forever begin
            exp_t e;
            int   cnt;
            wait (q.size() > 0);
            e = q[0];
            cnt = 0;
            @(negedge clk);
            while (busy[e.part] && cnt < 200) begin
                cnt++;
                @(negedge clk);
            end
            chk({e.tag, " busy cycles"}, cnt, e.cyc);
            chk({e.tag, " status"}, int'(status[e.part]), int'(e.st));
            chk({e.tag, " eff_code"}, int'(eff_code[e.part]), int'(e.eff));
            chk({e.tag, " locked"}, int'(locked[e.part]), int'(e.lk));
            void'(q.pop_front());
        end
    end

    task automatic write_code(int k, logic [W-1:0] c);
        wr_en[k] = 1'b1;
        wr_code[k] = c;
        @(negedge clk);
        wr_en[k] = 1'b0;
    endtask

    task automatic run_prog(int k, logic [1:0] st, int cyc, logic [W-1:0] eff,
                            logic lk, string tag);
        exp_t e;
        e.part = k; e.st = st; e.cyc = cyc; e.eff = eff; e.lk = lk; e.tag = tag;
        q.push_back(e);
        prog_req[k] = 1'b1;
        @(negedge clk);
        prog_req[k] = 1'b0;
        wr_en[k] = 1'b1;            // R2: write attempted while busy
        wr_code[k] = ~eff;
        @(negedge clk);
        wr_en[k] = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic try_again(int k, logic [1:0] st, string tag);
        prog_req[k] = 1'b1;
        @(negedge clk);
        prog_req[k] = 1'b0;
        chk({tag, " busy after repeat request"}, int'(busy[k]), 0);
        @(negedge clk);
        chk({tag, " busy later"}, int'(busy[k]), 0);
        chk({tag, " status kept"}, int'(status[k]), int'(st));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NP; k++) begin
            prog_req[k] = 1'b0; wr_en[k] = 1'b0; wr_code[k] = '0;
            flt_test[k] = 1'b0; flt_data[k] = '0; flt_lock[k] = 1'b0;
        end
        flt_test[1] = 1'b1;
        flt_data[2] = 6'b000010;   // bit 1 of 0x2B is 1: burn goes wrong
        flt_lock[3] = 1'b1;
        flt_data[4] = 6'b000100;   // bit 2 of 0x2B is 0: harmless
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < NP; k++) begin
            chk("R1 status", int'(status[k]), 0);
            chk("R1 busy", int'(busy[k]), 0);
            chk("R1 eff_code midscale", int'(eff_code[k]), 'h20);
            chk("R1 locked", int'(locked[k]), 0);
        end

        // R2 idle write, then R4/R6 clean programming with write while busy
        write_code(0, 6'h2B);
        chk("R2 write seen", int'(eff_code[0]), 'h2B);
        run_prog(0, 2'b11, 11, 6'h2B, 1'b1, "R4 R6 R2 clean part");
        write_code(0, 6'h07);
        chk("R7 write ignored when locked", int'(eff_code[0]), 'h2B);
        try_again(0, 2'b11, "R8 locked part");

        // R3 test fuse fault
        write_code(1, 6'h11);
        run_prog(1, 2'b01, 2, 6'h11, 1'b0, "R3 test fault");
        write_code(1, 6'h3F);
        chk("R2 write after 01 accepted", int'(eff_code[1]), 'h3F);
        try_again(1, 2'b01, "R8 part with 01");

        // R5 data fuse fault on a one bit
        write_code(2, 6'h2B);
        run_prog(2, 2'b10, 9, 6'h2B, 1'b0, "R5 data mismatch");
        try_again(2, 2'b10, "R8 part with 10");

        // R10 lock fuse fault
        write_code(3, 6'h2B);
        run_prog(3, 2'b10, 11, 6'h2B, 1'b0, "R10 lock fault");

        // R11 data fault on a zero bit
        write_code(4, 6'h2B);
        run_prog(4, 2'b11, 11, 6'h2B, 1'b1, "R11 harmless fault");

        // R9 power-on reset retention
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 R7 locked part eff after reset", int'(eff_code[0]), 'h2B);
        chk("R9 locked part status", int'(status[0]), 3);
        chk("R9 locked flag", int'(locked[0]), 1);
        chk("R9 part 01 status", int'(status[1]), 1);
        chk("R9 part 01 eff midscale", int'(eff_code[1]), 'h20);
        chk("R9 part 10 status", int'(status[2]), 2);
        chk("R9 part 10 eff midscale", int'(eff_code[2]), 'h20);
        chk("R9 R11 part eff after reset", int'(eff_code[4]), 'h2B);
        try_again(1, 2'b01, "R8 part 01 after reset");
        try_again(3, 2'b10, "R8 part 10 after reset");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule